// File: doc/BRIEF.md
# Serial Peripheral Slave Front End with Clock-Mode Detection

This block is the byte-level front end of a serial peripheral slave. It watches the chip-select (`csz`, active low), serial clock (`sck`), serial input (`si`) and write-protect (`wpz`, active low) pins. It uses its own system clock to do this, after passing the pins through a synchroniser. At every chip-select assertion it notes the idle level of the serial clock. From that level it decides whether the transaction runs in clock mode 0 (clock idles low) or mode 3 (clock idles high). In both modes the input is taken on rising clock edges and the output moves on falling clock edges, most significant bit first.

The first byte of each transaction goes to the core on `rx_byte` with an `instr_stb` pulse. Every later byte comes with a `data_stb` pulse. The core places read data on `rd_data`. That byte is sent on the falling edge that follows any completed byte. The output pin is driven only through `so_oe`.

The block also starts programming. A chip-select release that ends a complete write sequence raises a one-cycle `prog_start` and sets `busy`. `busy` stays high until the core answers with `prog_done`, whatever chip-select does in the meantime.

Top module: `spi_mode_slave`

## Requirements
- R1: `mode_o` takes the synchronised `sck` level seen when chip-select falls (0 selects mode 0, 1 selects mode 3) and keeps that value until the next falling chip-select.
- R2: While selected, `si` is shifted in on each rising `sck` edge, MSB first. When the first 8 bits after a chip-select fall are complete, they appear on `rx_byte` together with a one-cycle `instr_stb`.
- R3: Each later complete byte of the same transaction appears on `rx_byte` with a one-cycle `data_stb`, and `instr_stb` stays low for those bytes.
- R4: On the first falling `sck` edge after any completed byte, `rd_data` is loaded and its MSB is driven on `so`. Each further falling edge moves the next lower bit onto `so`. This works in both modes.
- R5: `so_oe` is low whenever `csz` is high. It is also low from reset until the first chip-select fall.
- R6: After reset, a transaction opens only on a high-to-low change of `csz`. Clock edges while `csz` has been held low since reset produce no strobes and no output enable.
- R7: Opcode 0x02 (memory write) followed by at least one more complete byte arms a write. The chip-select rise that ends such a sequence on a byte boundary gives a one-cycle `prog_start` and sets `busy`.
- R8: A chip-select rise in the middle of a byte discards the partial byte with no strobe, and no programming starts.
- R9: `busy` stays high from `prog_start` until `prog_done`, whatever chip-select does. A write opcode received while `busy` is high does not start programming.
- R10: Opcode 0x01 (status write) arms like R7, except when `wp_en` is 1 and `wpz` is 0. With `wp_en` at 0, `wpz` has no effect, and `wpz` never blocks opcode 0x02.
- R11: A strobe is visible SYNC_STAGES+1 system clock edges after the pin change that causes it.
- R12: A write opcode with no following complete byte starts no programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| csz | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wpz | input | 1 | Write-protect pin, active low |
| wp_en | input | 1 | Enables the write-protect pin function |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; when low the pad is high-impedance |
| mode_o | output | 1 | Detected clock mode: 0 for mode 0, 1 for mode 3 |
| rx_byte | output | DW | Most recent received byte |
| instr_stb | output | 1 | Pulse: `rx_byte` holds the instruction byte |
| data_stb | output | 1 | Pulse: `rx_byte` holds an address or data byte |
| rd_data | input | DW | Byte to send after the current byte boundary |
| prog_done | input | 1 | Core reports that programming has finished |
| prog_start | output | 1 | Pulse: start a programming cycle |
| busy | output | 1 | Programming in progress |

## Verification
Every pin change takes SYNC_STAGES cycles to cross the synchroniser and one more edge to register, so strobes, `prog_start` and `so` settle three system cycles after the `sck` or `csz` change that causes them. The bench measures this delay exactly for the instruction strobe by comparing the cycle count at the strobe with the cycle of the final rising `sck` drive. Every other result is sampled a half serial period (eight system cycles) after its cause. That is always past the due cycle and before the next pin change. Read bits are taken just before each rising `sck`, which is half a period after the falling edge that moved them.

// File: rtl/spi_ms_pkg.sv
package spi_ms_pkg;

   typedef enum logic {
      MODE_00 = 1'b0,
      MODE_11 = 1'b1
   } spi_mode_e;

   typedef struct packed {
      logic fall;
      logic rise;
   } edge_t;

endpackage

// File: rtl/spi_ms_sync.sv
module spi_ms_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ms_frame.sv
module spi_ms_frame
   import spi_ms_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  edge_t         cs_ev,
   input  logic          sck_rise,
   input  logic          sck_lvl,
   input  logic          si_lvl,
   output logic          active,
   output spi_mode_e     mode,
   output logic          bit_zero,
   output logic          any_byte,
   output logic          multi_byte,
   output logic [DW-1:0] rx_byte,
   output logic          instr_stb,
   output logic          data_stb
);
   localparam int BW = $clog2(DW);
   localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

   logic [BW-1:0] bit_q;
   logic [1:0]    byte_q;
   logic [DW-1:0] sh_q;
   logic [DW-1:0] next_sh;

   assign next_sh = {sh_q[DW-2:0], si_lvl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         mode      <= MODE_00;
         bit_q     <= '0;
         byte_q    <= '0;
         sh_q      <= '0;
         rx_byte   <= '0;
         instr_stb <= 1'b0;
         data_stb  <= 1'b0;
      end else begin
         instr_stb <= 1'b0;
         data_stb  <= 1'b0;
         if (cs_ev.fall) begin
            active <= 1'b1;
            mode   <= spi_mode_e'(sck_lvl);
            bit_q  <= '0;
            byte_q <= '0;
         end else if (cs_ev.rise) begin
            active <= 1'b0;
         end else if (active && sck_rise) begin
            sh_q <= next_sh;
            if (bit_q == LAST_BIT) begin
               bit_q   <= '0;
               rx_byte <= next_sh;
               if (byte_q == 2'd0) instr_stb <= 1'b1;
               else                data_stb  <= 1'b1;
               if (byte_q != 2'd3) byte_q <= byte_q + 2'd1;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   assign bit_zero   = (bit_q == '0);
   assign any_byte   = (byte_q != 2'd0);
   assign multi_byte = (byte_q >= 2'd2);
endmodule

// File: rtl/spi_ms_tx.sv
module spi_ms_tx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          cs_fall,
   input  logic          sck_fall,
   input  logic          bit_zero,
   input  logic          any_byte,
   input  logic [DW-1:0] rd_data,
   output logic          so
);
   logic [DW-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (cs_fall) begin
         sh_q <= '0;
      end else if (active && sck_fall) begin
         if (bit_zero) begin
            if (any_byte) sh_q <= rd_data;
         end else begin
            sh_q <= {sh_q[DW-2:0], 1'b0};
         end
      end
   end

   assign so = sh_q[DW-1];
endmodule

// File: rtl/spi_ms_prog.sv
module spi_ms_prog #(
   parameter int             DW         = 8,
   parameter logic [DW-1:0]  WR_MEM_OP  = 8'h02,
   parameter logic [DW-1:0]  WR_STAT_OP = 8'h01
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_fall,
   input  logic          cs_rise,
   input  logic          active,
   input  logic          instr_stb,
   input  logic [DW-1:0] rx_byte,
   input  logic          bit_zero,
   input  logic          multi_byte,
   input  logic          wp_en,
   input  logic          wpz_lvl,
   input  logic          prog_done,
   output logic          prog_start,
   output logic          busy
);
   logic arm_q;
   logic op_ok;
   logic stat_locked;

   assign stat_locked = wp_en && !wpz_lvl;
   assign op_ok = !busy &&
                  ((rx_byte == WR_MEM_OP) ||
                   ((rx_byte == WR_STAT_OP) && !stat_locked));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q      <= 1'b0;
         prog_start <= 1'b0;
         busy       <= 1'b0;
      end else begin
         prog_start <= 1'b0;
         if (cs_fall)        arm_q <= 1'b0;
         else if (instr_stb) arm_q <= op_ok;
         if (cs_rise && active && arm_q && bit_zero && multi_byte) begin
            prog_start <= 1'b1;
            busy       <= 1'b1;
            arm_q      <= 1'b0;
         end else if (prog_done) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_mode_slave.sv
module spi_mode_slave
   import spi_ms_pkg::*;
#(
   parameter int            DW          = 8,
   parameter int            SYNC_STAGES = 2,
   parameter logic [DW-1:0] WR_MEM_OP   = 8'h02,
   parameter logic [DW-1:0] WR_STAT_OP  = 8'h01
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csz,
   input  logic          sck,
   input  logic          si,
   input  logic          wpz,
   input  logic          wp_en,
   output logic          so,
   output logic          so_oe,
   output logic          mode_o,
   output logic [DW-1:0] rx_byte,
   output logic          instr_stb,
   output logic          data_stb,
   input  logic [DW-1:0] rd_data,
   input  logic          prog_done,
   output logic          prog_start,
   output logic          busy
);
   localparam int NPIN = 4;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (WR_MEM_OP == WR_STAT_OP) begin : g_bad_ops
      $error("write opcodes must differ");
   end

   logic [NPIN-1:0] pin_s;
   logic            cs_l, sck_l, si_l, wpz_l;
   logic            cs_prev_q, sck_prev_q;
   edge_t           cs_ev;
   logic            sck_rise, sck_fall;
   logic            act_w, bit_zero_w, any_byte_w, multi_w;
   spi_mode_e       mode_w;

   spi_ms_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({wpz, si, sck, csz}),
      .q     (pin_s)
   );

   assign {wpz_l, si_l, sck_l, cs_l} = pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev_q  <= 1'b0;
         sck_prev_q <= 1'b0;
      end else begin
         cs_prev_q  <= cs_l;
         sck_prev_q <= sck_l;
      end
   end

   assign cs_ev.fall = cs_prev_q & ~cs_l;
   assign cs_ev.rise = ~cs_prev_q & cs_l;
   assign sck_rise   = ~sck_prev_q & sck_l;
   assign sck_fall   = sck_prev_q & ~sck_l;

   spi_ms_frame #(.DW(DW)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_ev      (cs_ev),
      .sck_rise   (sck_rise),
      .sck_lvl    (sck_l),
      .si_lvl     (si_l),
      .active     (act_w),
      .mode       (mode_w),
      .bit_zero   (bit_zero_w),
      .any_byte   (any_byte_w),
      .multi_byte (multi_w),
      .rx_byte    (rx_byte),
      .instr_stb  (instr_stb),
      .data_stb   (data_stb)
   );

   spi_ms_tx #(.DW(DW)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (act_w),
      .cs_fall  (cs_ev.fall),
      .sck_fall (sck_fall),
      .bit_zero (bit_zero_w),
      .any_byte (any_byte_w),
      .rd_data  (rd_data),
      .so       (so)
   );

   spi_ms_prog #(.DW(DW), .WR_MEM_OP(WR_MEM_OP), .WR_STAT_OP(WR_STAT_OP)) u_prog (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_fall    (cs_ev.fall),
      .cs_rise    (cs_ev.rise),
      .active     (act_w),
      .instr_stb  (instr_stb),
      .rx_byte    (rx_byte),
      .bit_zero   (bit_zero_w),
      .multi_byte (multi_w),
      .wp_en      (wp_en),
      .wpz_lvl    (wpz_l),
      .prog_done  (prog_done),
      .prog_start (prog_start),
      .busy       (busy)
   );

   assign mode_o = (mode_w == MODE_11);
   assign so_oe  = act_w & ~csz;
endmodule

// File: rtl/spi_mode_slave_chk.sv
module spi_mode_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic csz,
   input logic so_oe,
   input logic mode_o,
   input logic active,
   input logic instr_stb,
   input logic data_stb,
   input logic prog_start,
   input logic prog_done,
   input logic busy
);
   a_r5_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      csz |-> !so_oe);

   a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(mode_o));

   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_stb && data_stb));

   a_r6_strobe_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_stb || data_stb) |-> $past(active));

   a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start);

   a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> busy);

   a_r9_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !prog_done) |=> busy);

   a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> !$past(busy));
endmodule

bind spi_mode_slave spi_mode_slave_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .csz        (csz),
   .so_oe      (so_oe),
   .mode_o     (mode_o),
   .active     (act_w),
   .instr_stb  (instr_stb),
   .data_stb   (data_stb),
   .prog_start (prog_start),
   .prog_done  (prog_done),
   .busy       (busy)
);

// File: tb/test_spi_mode_slave.sv
module test_spi_mode_slave;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int H          = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       csz, sck, si, wpz, wp_en, prog_done;
   logic [7:0] rd_data;
   logic       so, so_oe, mode_o, instr_stb, data_stb, prog_start, busy;
   logic [7:0] rx_byte;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int n_instr = 0, n_data = 0, n_start = 0;
   int instr_cyc = 0, last_rise = 0;
   logic [7:0] last_instr = '0, last_data = '0;
   bit mode_cur = 1'b0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spi_mode_slave i_spi_mode_slave (
      .clk(clk), .rst_n(rst_n), .csz(csz), .sck(sck), .si(si), .wpz(wpz),
      .wp_en(wp_en), .so(so), .so_oe(so_oe), .mode_o(mode_o),
      .rx_byte(rx_byte), .instr_stb(instr_stb), .data_stb(data_stb),
      .rd_data(rd_data), .prog_done(prog_done), .prog_start(prog_start),
      .busy(busy)
   );

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (instr_stb) begin n_instr++; last_instr = rx_byte; instr_cyc = cyc; end
         if (data_stb)  begin n_data++;  last_data  = rx_byte; end
         if (prog_start) n_start++;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_begin(input bit m);
      mode_cur = m;
      sck = m;
      wait_n(H);
      csz = 1'b0;
      wait_n(H);
   endtask

   task automatic cs_end();
      wait_n(H);
      csz = 1'b1;
      wait_n(H);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
      rx = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         if (mode_cur == 1'b0) begin
            si = tx[i];
            wait_n(H);
            rx[i] = so;
            sck = 1'b1; last_rise = cyc;
            wait_n(H);
            sck = 1'b0;
         end else begin
            sck = 1'b0;
            si = tx[i];
            wait_n(H);
            rx[i] = so;
            sck = 1'b1; last_rise = cyc;
            wait_n(H);
         end
      end
   endtask

   task automatic pulse_done();
      @(negedge clk) prog_done = 1'b1;
      @(negedge clk) prog_done = 1'b0;
      wait_n(3);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic t_reset();
      chk("R5", "so_oe after reset", int'(so_oe), 0);
      chk("R9", "busy after reset", int'(busy), 0);
      chk("R7", "prog_start after reset", int'(prog_start), 0);
   endtask

   task automatic t_held_low();
      logic [7:0] r;
      int b0 = n_instr;
      mode_cur = 1'b0;
      xfer(8'h02, r);
      chk("R6", "strobes with csz low since reset", n_instr - b0, 0);
      chk("R6", "so_oe with csz low since reset", int'(so_oe), 0);
      csz = 1'b1;
      wait_n(H);
   endtask

   task automatic t_mode0();
      logic [7:0] r;
      int bi = n_instr, bd = n_data, bs = n_start;
      rd_data = 8'h5C;
      cs_begin(1'b0);
      chk("R1", "mode_o for idle-low clock", int'(mode_o), 0);
      xfer(8'h5A, r);
      wait_n(1);
      chk("R2", "instruction byte", int'(last_instr), 'h5A);
      chk("R2", "instruction strobe count", n_instr - bi, 1);
      chk("R11", "instruction strobe latency", instr_cyc - last_rise, SYNC + 1);
      xfer(8'hC3, r);
      chk("R3", "data byte", int'(last_data), 'hC3);
      chk("R3", "data strobe count", n_data - bd, 1);
      chk("R5", "so_oe while selected", int'(so_oe), 1);
      xfer(8'h00, r);
      chk("R4", "read byte in mode 0", int'(r), 'h5C);
      chk("R3", "no extra instruction strobe", n_instr - bi, 1);
      cs_end();
      chk("R5", "so_oe after release", int'(so_oe), 0);
      chk("R7", "non-write opcode starts nothing", n_start - bs, 0);
   endtask

   task automatic t_mode3_read();
      logic [7:0] r;
      rd_data = 8'hA6;
      cs_begin(1'b1);
      chk("R1", "mode_o for idle-high clock", int'(mode_o), 1);
      xfer(8'h03, r);
      xfer(8'h40, r);
      xfer(8'h00, r);
      chk("R4", "first read byte in mode 3", int'(r), 'hA6);
      rd_data = 8'h3C;
      xfer(8'h00, r);
      chk("R4", "second read byte in mode 3", int'(r), 'h3C);
      chk("R1", "mode_o held through transaction", int'(mode_o), 1);
      cs_end();
      chk("R5", "so_oe after mode 3 release", int'(so_oe), 0);
   endtask

   task automatic t_write_busy();
      logic [7:0] r;
      int bs = n_start;
      cs_begin(1'b0);
      xfer(8'h02, r); xfer(8'h00, r); xfer(8'h11, r);
      cs_end();
      chk("R7", "memory write starts programming", n_start - bs, 1);
      chk("R7", "busy after start", int'(busy), 1);
      bs = n_start;
      cs_begin(1'b1);
      xfer(8'h02, r); xfer(8'h01, r); xfer(8'h22, r);
      cs_end();
      chk("R9", "write while busy ignored", n_start - bs, 0);
      chk("R9", "busy held across chip-select", int'(busy), 1);
      pulse_done();
      chk("R9", "busy cleared by prog_done", int'(busy), 0);
   endtask

   task automatic t_partial();
      logic [7:0] r;
      int bs = n_start, bd = n_data;
      cs_begin(1'b0);
      xfer(8'h02, r); xfer(8'h00, r); xfer(8'hFF, r, 3);
      cs_end();
      chk("R8", "partial byte gives no strobe", n_data - bd, 1);
      chk("R8", "partial byte blocks programming", n_start - bs, 0);
   endtask

   task automatic t_instr_only();
      logic [7:0] r;
      int bs = n_start;
      cs_begin(1'b1);
      xfer(8'h02, r);
      cs_end();
      chk("R12", "opcode alone starts nothing", n_start - bs, 0);
      chk("R12", "busy stays low", int'(busy), 0);
   endtask

   task automatic t_protect();
      logic [7:0] r;
      int bs;
      wp_en = 1'b1; wpz = 1'b0;
      bs = n_start;
      cs_begin(1'b0);
      xfer(8'h01, r); xfer(8'h80, r);
      cs_end();
      chk("R10", "status write blocked by pin", n_start - bs, 0);
      bs = n_start;
      cs_begin(1'b0);
      xfer(8'h02, r); xfer(8'h10, r); xfer(8'h55, r);
      cs_end();
      chk("R10", "memory write not blocked by pin", n_start - bs, 1);
      pulse_done();
      wpz = 1'b1;
      bs = n_start;
      cs_begin(1'b1);
      xfer(8'h01, r); xfer(8'h80, r);
      cs_end();
      chk("R10", "status write with pin high", n_start - bs, 1);
      pulse_done();
      wp_en = 1'b0; wpz = 1'b0;
      bs = n_start;
      cs_begin(1'b0);
      xfer(8'h01, r); xfer(8'h04, r);
      cs_end();
      chk("R10", "pin ignored when function off", n_start - bs, 1);
      pulse_done();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; csz = 1'b0; sck = 1'b0; si = 1'b0;
      wpz = 1'b1; wp_en = 1'b0; prog_done = 1'b0; rd_data = '0;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(4);
      t_reset();
      t_held_low();
      t_mode0();
      t_mode3_read();
      t_write_busy();
      t_partial();
      t_instr_only();
      t_protect();
      finish_run();
   end
endmodule